// File: doc/BRIEF.md
# Centre-Aligned Dual-Slope PWM Timer

This block is a free-running timer that produces a symmetric pulse-width-modulated output. An up/down counter climbs from zero to its all-ones value, reverses, and descends back to zero, then repeats. Each up-then-down sweep is one PWM period. The output bit is driven whenever the count equals a compare value, and the direction of travel decides whether it is driven low or high. The pulse is therefore always centred on the middle of the period, whatever the duty cycle.

Software writes a new compare value into a holding register at any time. The timer copies that value into the working compare register only at the top turning point, so a period never mixes two duty values. The counter moves only on cycles where the timer-enable input is high. Two sticky flags report the bottom turning point and compare matches, and a single clear strobe resets both. All state uses a synchronous active-low reset.

Top module: `centered_pwm_timer`

## Requirements
- R1: On enabled cycles the count follows 0, 1, …, MAX, MAX-1, …, 1, 0, 1, … where MAX is all ones (255 at the default 8-bit width). Both MAX and 0 appear for exactly one enabled cycle, so one period is 2·MAX enabled cycles.
- R2: When `tmr_tick` is low, the count, direction, output and flags keep their values.
- R3: While `rst_n` is low at a clock edge, the count becomes 0, the direction becomes up, `pwm_out` becomes 0, both flags become 0, and both compare registers become 0.
- R4: With `cmp_mode` = 2'b10 (non-inverting), an enabled cycle whose count equals the working compare value drives `pwm_out` to 0 if the counter is on its rising phase (count 0 up to MAX-1) and to 1 if it is on its falling phase (count MAX down to 1). The new value is visible after that cycle's clock edge.
- R5: With `cmp_mode` = 2'b11 (inverting), the actions of R4 are swapped: 1 on a rising-phase match and 0 on a falling-phase match.
- R6: With `cmp_mode` = 2'b00 or 2'b01, `pwm_out` keeps its last value.
- R7: A cycle with `cmp_wr` high stores `cmp_wdata` in the holding register. On the clock edge where the count steps to MAX, the working compare register takes the holding value as it stood before that edge. Matches always use the working register.
- R8: `bot_flag` is set on the edge where the count steps from 1 to 0, which happens once per period.
- R9: `hit_flag` is set on every enabled cycle whose count equals the working compare value.
- R10: `flag_clr` clears both flags. A set in the same cycle takes priority over the clear.
- R11: In non-inverting mode, a compare value of 0 keeps `pwm_out` low. A compare value of MAX keeps `pwm_out` high once the first MAX has been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_tick | input | 1 | Timer enable; the counter advances on cycles where this is high |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | CNT_W | Compare value to store |
| cmp_mode | input | 2 | Output action select (00/01 hold, 10 non-inverting, 11 inverting) |
| flag_clr | input | 1 | Clears both sticky flags |
| pwm_out | output | 1 | PWM output bit |
| count | output | CNT_W | Live counter value |
| bot_flag | output | 1 | Sticky bottom-reached flag |
| hit_flag | output | 1 | Sticky compare-match flag |

## Verification
The bench uses a 4-bit counter and sweeps every compare value, from 0 to all ones, in both the non-inverting and the inverting mode. This sweep distinguishes the rising-phase action from the falling-phase action. It also exposes the boundary values, where only one turning point can match. Some runs gate the enable in an irregular pattern, which separates advancing on the enable from advancing every clock. Other runs write the compare value mid-period and switch to the hold modes part-way through, which shows whether the compare value is taken only at the top and whether the output is frozen. Flag clears are issued on a fixed stride that sometimes lands on a set cycle, which exercises the set-over-clear priority.

// File: rtl/cpwm_pkg.sv
// Package: shared encodings for the centre-aligned PWM timer.
// Assumes: two-bit output-mode field; values 0 and 1 leave the pin untouched.
package cpwm_pkg;
    typedef enum logic [1:0] {
        CMODE_HOLD0  = 2'b00,
        CMODE_HOLD1  = 2'b01,
        CMODE_NONINV = 2'b10,
        CMODE_INV    = 2'b11
    } cmp_mode_e;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_BOT  = 0;
    localparam int FLAG_HIT  = 1;
endpackage

// File: rtl/cpwm_updown_ctr.sv
// Module: up/down sweep counter. Steps by one on each enabled cycle,
// turns at all-ones and at zero, and spends one enabled cycle at each end.
// Assumes: CNT_W >= 2. The up flag gives the direction of the next step.
module cpwm_updown_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             going_up,
    output logic             reach_top,
    output logic             reach_bot
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_nxt;

    // Purpose: next count and turning-point strobes for this cycle.
    always_comb begin
        count_nxt = going_up ? (count + CNT_ONE) : (count - CNT_ONE);
        reach_top = tick && going_up  && (count == (CNT_TOP - CNT_ONE));
        reach_bot = tick && !going_up && (count == CNT_ONE);
    end

    // Purpose: register the count and reverse direction at each end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            going_up <= 1'b1;
        end else if (tick) begin
            count <= count_nxt;
            if (reach_top) begin
                going_up <= 1'b0;
            end else if (reach_bot) begin
                going_up <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpwm_cmp_buf.sv
// Module: double-buffered compare value. Software writes land in a holding
// register; the working register takes the holding value on a load strobe.
// Assumes: on a load with a write in the same cycle, the load takes the old
// holding value.
module cpwm_cmp_buf #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             load,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] hold_q;

    // Purpose: capture software writes into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr) begin
            hold_q <= wdata;
        end
    end

    // Purpose: move the holding value into the working register at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (load) begin
            active <= hold_q;
        end
    end
endmodule

// File: rtl/cpwm_wave_out.sv
// Module: compare detector and output stage. On an enabled match it clears or
// sets the output depending on direction and mode; hold modes keep the bit.
// Assumes: the up flag is low while the count sits at the top value.
module cpwm_wave_out
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             going_up,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       mode,
    output logic             hit,
    output logic             wave
);
    cmp_mode_e mode_e;

    // Purpose: decode the mode and detect an enabled compare match.
    always_comb begin
        mode_e = cmp_mode_e'(mode);
        hit    = tick && (count == cmp_val);
    end

    // Purpose: apply the direction-dependent action to the output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else if (hit) begin
            case (mode_e)
                CMODE_NONINV: wave <= !going_up;
                CMODE_INV:    wave <= going_up;
                default:      wave <= wave;
            endcase
        end
    end
endmodule

// File: rtl/cpwm_flags.sv
// Module: bank of sticky event flags with a shared clear; set beats clear.
// Assumes: set inputs are single-cycle strobes.
module cpwm_flags #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set,
    input  logic           clr,
    output logic [NUM-1:0] flags
);
    for (genvar g = 0; g < NUM; g++) begin : g_flag
        // Purpose: one sticky bit, set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[g] <= 1'b0;
            end else if (set[g]) begin
                flags[g] <= 1'b1;
            end else if (clr) begin
                flags[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/centered_pwm_timer.sv
// Module: top of the centre-aligned dual-slope PWM timer. Connects the sweep
// counter, the compare double buffer, the output stage and the flag bank.
// Assumes: tmr_tick comes from an external prescaler; synchronous reset.
module centered_pwm_timer
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_tick,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       cmp_mode,
    input  logic             flag_clr,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count,
    output logic             bot_flag,
    output logic             hit_flag
);
    logic                 going_up;
    logic                 reach_top;
    logic                 reach_bot;
    logic                 hit;
    logic [CNT_W-1:0]     cmp_active;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;

    cpwm_updown_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tmr_tick),
        .count     (count),
        .going_up  (going_up),
        .reach_top (reach_top),
        .reach_bot (reach_bot)
    );

    cpwm_cmp_buf #(.CNT_W(CNT_W)) cbuf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmp_wr),
        .wdata  (cmp_wdata),
        .load   (reach_top),
        .active (cmp_active)
    );

    cpwm_wave_out #(.CNT_W(CNT_W)) wave_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tmr_tick),
        .count    (count),
        .going_up (going_up),
        .cmp_val  (cmp_active),
        .mode     (cmp_mode),
        .hit      (hit),
        .wave     (pwm_out)
    );

    // Purpose: route event strobes to their flag slots.
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_BOT] = reach_bot;
        flag_set[FLAG_HIT] = hit;
    end

    cpwm_flags #(.NUM(NUM_FLAGS)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flags (flag_q)
    );

    assign bot_flag = flag_q[FLAG_BOT];
    assign hit_flag = flag_q[FLAG_HIT];
endmodule

// File: rtl/centered_pwm_timer_chk.sv
// Module: property checker for the PWM timer, attached by bind.
// Assumes: observes only the top-level ports.
module centered_pwm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_tick,
    input logic [1:0]       cmp_mode,
    input logic             flag_clr,
    input logic             pwm_out,
    input logic [CNT_W-1:0] count,
    input logic             bot_flag,
    input logic             hit_flag
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_tick |=> ($stable(count) && $stable(pwm_out)));

    p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_tick |=> ((count == $past(count) + ONE) || (count == $past(count) - ONE)));

    p_top_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && count == TOP) |=> (count == TOP - ONE));

    p_bot_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bot_flag) |-> (count == '0));

    p_hold_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_mode[1] |=> $stable(pwm_out));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !tmr_tick) |=> (!bot_flag && !hit_flag));
endmodule

bind centered_pwm_timer centered_pwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_tick (tmr_tick),
    .cmp_mode (cmp_mode),
    .flag_clr (flag_clr),
    .pwm_out  (pwm_out),
    .count    (count),
    .bot_flag (bot_flag),
    .hit_flag (hit_flag)
);

// File: tb/centered_pwm_timer_tb_top.sv
// Bench: 4-bit configuration, exhaustive compare sweep, arithmetic model.
module centered_pwm_timer_tb_top;
    localparam int W  = 4;
    localparam int M  = (1 << W) - 1;
    localparam int PER = 2 * M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tmr_tick = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic [1:0]   cmp_mode = 2'b10;
    logic         flag_clr = 1'b0;
    logic         pwm_out;
    logic [W-1:0] count;
    logic         bot_flag;
    logic         hit_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state: position in period and expected outputs.
    int m_pos = 0;
    int m_buf = 0;
    int m_act = 0;
    bit m_out = 0;
    bit m_bot = 0;
    bit m_hit = 0;

    always #5 clk = ~clk;

    centered_pwm_timer #(.CNT_W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_tick  (tmr_tick),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .cmp_mode  (cmp_mode),
        .flag_clr  (flag_clr),
        .pwm_out   (pwm_out),
        .count     (count),
        .bot_flag  (bot_flag),
        .hit_flag  (hit_flag)
    );

    function automatic int cnt_of(input int p);
        return (p <= M) ? p : (PER - p);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, advance the model, sample 2 ns after the edge.
    task automatic cyc(input bit t, input bit wr, input int wd, input bit clr);
        string oreq;
        bit set_b, set_h;
        int nact;
        @(negedge clk);
        tmr_tick  = t;
        cmp_wr    = wr;
        cmp_wdata = W'(wd);
        flag_clr  = clr;
        set_b = 0; set_h = 0; nact = m_act;
        if (cmp_mode == 2'b10)      oreq = (m_act == 0 || m_act == M) ? "R11" : "R4";
        else if (cmp_mode == 2'b11) oreq = "R5";
        else                        oreq = "R6";
        if (t) begin
            if (cnt_of(m_pos) == m_act) begin
                set_h = 1;
                if (cmp_mode == 2'b10) m_out = !(m_pos < M);
                if (cmp_mode == 2'b11) m_out = (m_pos < M);
            end
            m_pos = (m_pos + 1) % PER;
            if (cnt_of(m_pos) == M) nact = m_buf;  // R7 load at top
            if (m_pos == 0) set_b = 1;
        end
        if (clr) begin m_bot = 0; m_hit = 0; end
        if (set_b) m_bot = 1;
        if (set_h) m_hit = 1;
        if (wr) m_buf = wd;
        m_act = nact;
        @(posedge clk);
        #2;
        check(t ? "R1" : "R2", "count", int'(count), cnt_of(m_pos));
        check(oreq, "pwm_out", int'(pwm_out), int'(m_out));
        check(clr ? "R10" : "R8", "bot_flag", int'(bot_flag), int'(m_bot));
        check(clr ? "R10" : "R9", "hit_flag", int'(hit_flag), int'(m_hit));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tmr_tick = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tmr_tick = 1'b0;
        m_pos = 0; m_buf = 0; m_act = 0; m_out = 0; m_bot = 0; m_hit = 0;
        #1;
        check("R3", "count", int'(count), 0);
        check("R3", "pwm_out", int'(pwm_out), 0);
        check("R3", "bot_flag", int'(bot_flag), 0);
        check("R3", "hit_flag", int'(hit_flag), 0);
    endtask

    initial begin
        do_reset();
        // Exhaustive sweep: both active modes, every compare value (R4 R5 R11 R7).
        for (int md = 2; md <= 3; md++) begin
            cmp_mode = 2'(md);
            for (int c = 0; c <= M; c++) begin
                cyc(1, 1, c, 0);
                for (int i = 0; i < 2 * PER + 3; i++) cyc(1, 0, 0, (i % 7) == 3);
            end
        end
        // Irregular enable gating (R2) with mid-period writes (R7).
        cmp_mode = 2'b10;
        for (int i = 0; i < 6 * PER; i++)
            cyc((i % 3) != 0, (i % 23) == 5, (i * 5) % (M + 1), (i % 11) == 4);
        // Hold modes: output frozen while count keeps moving (R6).
        for (int md = 0; md <= 1; md++) begin
            cmp_mode = 2'(md);
            for (int i = 0; i < 2 * PER; i++) cyc(1, (i % 9) == 1, (i * 3) % (M + 1), 0);
        end
        cmp_mode = 2'b11;
        for (int i = 0; i < 2 * PER; i++) cyc(1, 0, 0, (i % 5) == 0);
        // Reset in mid-run returns everything to its initial state (R3).
        do_reset();
        cmp_mode = 2'b10;
        cyc(1, 1, M / 2, 0);
        for (int i = 0; i < 2 * PER; i++) cyc(1, 0, 0, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule